// File: doc/BRIEF.md
# Reservation-Table Issue Scheduler

This block decides when each instruction of an in-order pipeline may start and which functional unit arrangement it uses. It keeps a table of future cycles, each entry a mask of units already booked for that cycle. An offered instruction class maps to a short ordered list of two-cycle unit patterns. The block takes the first pattern that does not collide with existing bookings and merges it into the table. The memory units stay booked longer when the offered cache latency is nonzero. When no pattern fits, the pipeline advances one cycle: the table shifts toward the present and a cycle counter counts the stall.

Requests arrive on a valid/ready stream. `in_ready` is computed in the same cycle from the offered class, the offered latency and the table. A transfer (`in_valid` and `in_ready` high at a rising edge) is an issue. While `in_ready` is low the block keeps no record of the offer. The source may hold the offer, change it or withdraw it. Each clock with `in_valid` high and no fitting pattern is a stall cycle, unless the offer can never fit in the table. Such an offer is held with no time advance. Only the stall cycles let bookings drain.

Top module: `rsv_issue_sched`

## Requirements
- R1: After reset the table is empty and both counters read zero. The first offer of any class with latency 0 gets `in_ready` high and variant 0.
- R2: Unit masks are ALU1=0x04, ALU2=0x08, FPU=0x10, LOAD=0x20 and STORE=0x40. Class code 0 is ALU. Its variants, in the order they are tried, are: 0 = ALU1 in cycle 0, 1 = ALU1 in cycle 1, 2 = ALU2 in cycle 0, 3 = ALU2 in cycle 1.
- R3: Class code 1 is FPU, with only variant 0. It books the FPU in cycles 0 and 1.
- R4: Class code 2 is load and class code 3 is store. Variant 0 books ALU1 in cycle 0 and variant 1 books ALU2 in cycle 0. Both variants then book the memory unit (LOAD for a load, STORE for a store) from cycle 1.
- R5: A variant is rejected when any cycle of its footprint shares a unit with the bookings for that cycle. The lowest-numbered variant that is not rejected is issued and reported on `issue_variant`.
- R6: An issue merges the footprint into the table without advancing time and adds one to `issued_count`.
- R7: With offered cache latency L, the memory unit of a load or store is booked in cycles 1 through 1+L.
- R8: An offer with `in_valid` high and no fitting variant gets `in_ready` low. At the edge, the table shifts by one cycle (the oldest entry is dropped and an empty entry enters at the far end) and `cycle_count` adds one.
- R9: A load or store with 2+L greater than the table depth (16 by default) gets `in_ready` low. It leaves the table and both counters unchanged.
- R10: With `in_valid` low, the table and both counters hold.
- R11: `issue_o` is high exactly when `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction class is offered |
| in_ready | output | 1 | The offered class fits now |
| in_class | input | 2 | 0 ALU, 1 FPU, 2 load, 3 store |
| in_cache_lat | input | LAT_W (4) | Extra memory-unit cycles for a load or store |
| issue_o | output | 1 | Issue this cycle |
| issue_variant | output | 2 | Index of the chosen pattern |
| cycle_count | output | 64 | Stall cycles advanced since reset |
| issued_count | output | 64 | Instructions issued since reset |

## Verification
A wrong booking or a wrong shift in the table does not show up at once. It shows up at the next offer whose footprint covers the corrupted cycle, as a wrong `in_ready` or a wrong variant index. It can also show up as one extra or one missing increment of `cycle_count` while the offer waits. Long cache latencies keep memory bookings in the table for up to 16 cycles, so the bench mixes directed ordering cases with long random streams. Every clock it compares the ready, issue and variant outputs and both counters against an independent table model.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int UW       = 7;
  localparam int MAX_CAND = 4;
  localparam int VW       = $clog2(MAX_CAND);

  typedef logic [UW-1:0] umask_t;

  localparam umask_t U_NONE  = 7'h00;
  localparam umask_t U_ALU1  = 7'h04;
  localparam umask_t U_ALU2  = 7'h08;
  localparam umask_t U_FPU   = 7'h10;
  localparam umask_t U_LOAD  = 7'h20;
  localparam umask_t U_STORE = 7'h40;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_FPU   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } iclass_e;

  typedef struct packed {
    logic   ok;
    umask_t c0;
    umask_t c1;
  } pat_t;

  function automatic logic is_mem(umask_t m);
    return (m & (U_LOAD | U_STORE)) != U_NONE;
  endfunction

  // Ordered alternatives per class; index order is the try order.
  function automatic pat_t pattern_of(iclass_e c, int unsigned idx);
    pat_t p;
    p = '{ok: 1'b0, c0: U_NONE, c1: U_NONE};
    case (c)
      CLS_ALU: begin
        p.ok = 1'b1;
        case (idx)
          0:       p.c0 = U_ALU1;
          1:       p.c1 = U_ALU1;
          2:       p.c0 = U_ALU2;
          default: p.c1 = U_ALU2;
        endcase
      end
      CLS_FPU: if (idx == 0) p = '{ok: 1'b1, c0: U_FPU, c1: U_FPU};
      CLS_LOAD: begin
        if (idx == 0)      p = '{ok: 1'b1, c0: U_ALU1, c1: U_LOAD};
        else if (idx == 1) p = '{ok: 1'b1, c0: U_ALU2, c1: U_LOAD};
      end
      default: begin
        if (idx == 0)      p = '{ok: 1'b1, c0: U_ALU1, c1: U_STORE};
        else if (idx == 1) p = '{ok: 1'b1, c0: U_ALU2, c1: U_STORE};
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/rsv_footprint.sv
module rsv_footprint
  import rsv_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LAT_W = 4
) (
  input  umask_t                      c0,
  input  umask_t                      c1,
  input  logic [LAT_W-1:0]            lat,
  input  logic [DEPTH-1:0][UW-1:0]    occ,
  output logic [DEPTH-1:0][UW-1:0]    fp,
  output logic                        clash,
  output logic                        ovf
);
  int s0;
  int s1;

  always_comb begin
    s0 = is_mem(c0) ? int'(lat) : 0;
    s1 = is_mem(c1) ? int'(lat) : 0;
    fp = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k <= s0)
        fp[k] = fp[k] | c0;
      if (k > s0 && k <= s0 + 1 + s1)
        fp[k] = fp[k] | c1;
    end
    ovf   = (s0 + s1 + 2) > DEPTH;
    clash = |(fp & occ);
  end
endmodule

// File: rtl/rsv_occ_table.sv
module rsv_occ_table
  import rsv_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     book_en,
  input  logic [DEPTH-1:0][UW-1:0] book_fp,
  input  logic                     shift_en,
  output logic [DEPTH-1:0][UW-1:0] occ
);
  logic [DEPTH-1:0][UW-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      occ_q <= '0;
    else if (shift_en)
      occ_q <= {umask_t'(0), occ_q[DEPTH-1:1]};
    else if (book_en)
      occ_q <= occ_q | book_fp;
  end

  assign occ = occ_q;

  AST_NO_DOUBLE_BOOK: assert property (@(posedge clk) disable iff (!rst_n)
    book_en |-> ((occ_q & book_fp) == '0)); // R5
endmodule

// File: rtl/rsv_counters.sv
module rsv_counters #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_issue,
  input  logic             inc_cycle,
  output logic [CNT_W-1:0] issued,
  output logic [CNT_W-1:0] cycles
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued <= '0;
      cycles <= '0;
    end else begin
      if (inc_issue) issued <= issued + 1'b1;
      if (inc_cycle) cycles <= cycles + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_issue_sched.sv
module rsv_issue_sched
  import rsv_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LAT_W = 4,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_class,
  input  logic [LAT_W-1:0] in_cache_lat,
  output logic             issue_o,
  output logic [VW-1:0]    issue_variant,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] issued_count
);
  logic [DEPTH-1:0][UW-1:0] occ;
  logic [DEPTH-1:0][UW-1:0] fp_c [MAX_CAND];
  logic [MAX_CAND-1:0]      clash_c;
  logic [MAX_CAND-1:0]      ovf_c;
  pat_t                     pat_c [MAX_CAND];

  logic          any_fit;
  logic          any_ovf;
  logic [VW-1:0] sel;
  logic          stall;

  for (genvar g = 0; g < MAX_CAND; g++) begin : g_cand
    assign pat_c[g] = pattern_of(iclass_e'(in_class), g);
    rsv_footprint #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_fp (
      .c0    (pat_c[g].c0),
      .c1    (pat_c[g].c1),
      .lat   (in_cache_lat),
      .occ   (occ),
      .fp    (fp_c[g]),
      .clash (clash_c[g]),
      .ovf   (ovf_c[g])
    );
  end

  always_comb begin
    any_fit = 1'b0;
    any_ovf = 1'b0;
    sel     = '0;
    for (int i = 0; i < MAX_CAND; i++) begin
      if (pat_c[i].ok && ovf_c[i])
        any_ovf = 1'b1;
      if (!any_fit && pat_c[i].ok && !clash_c[i] && !ovf_c[i]) begin
        any_fit = 1'b1;
        sel     = VW'(i);
      end
    end
  end

  assign in_ready      = any_fit;
  assign issue_o       = in_valid && any_fit;
  assign stall         = in_valid && !any_fit && !any_ovf;
  assign issue_variant = sel;

  rsv_occ_table #(.DEPTH(DEPTH)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .book_en  (issue_o),
    .book_fp  (fp_c[sel]),
    .shift_en (stall),
    .occ      (occ)
  );

  rsv_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_issue (issue_o),
    .inc_cycle (stall),
    .issued    (issued_count),
    .cycles    (cycle_count)
  );

  AST_CYCLE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_count != $past(cycle_count)) |-> $past(in_valid && !in_ready)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_valid) |-> ($stable(cycle_count) && $stable(issued_count))); // R10
  AST_FPU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && in_class == 2'd1) |-> (issue_variant == '0)); // R3
  AST_OVF_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && any_ovf) |-> ($stable(cycle_count) && $stable(issued_count))); // R9
endmodule

// File: tb/rsv_issue_sched_tb.sv
module rsv_issue_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = 2'd0;
  logic [3:0]  in_cache_lat = 4'd0;
  logic        issue_o;
  logic [1:0]  issue_variant;
  logic [63:0] cycle_count;
  logic [63:0] issued_count;

  int checks = 0;
  int errors = 0;
  int     m_occ [DEPTH];
  int     fpb [DEPTH];
  longint m_cyc = 0;
  longint m_iss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsv_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_cache_lat(in_cache_lat), .issue_o(issue_o),
    .issue_variant(issue_variant), .cycle_count(cycle_count),
    .issued_count(issued_count)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ncand(int cls);
    return (cls == 0) ? 4 : (cls == 1) ? 1 : 2;
  endfunction

  function automatic int first_mask(int cls, int v);
    case (cls)
      0: return (v == 0) ? 4 : (v == 2) ? 8 : 0;
      1: return 16;
      default: return (v == 0) ? 4 : 8;
    endcase
  endfunction

  function automatic int second_mask(int cls, int v);
    case (cls)
      0: return (v == 1) ? 4 : (v == 3) ? 8 : 0;
      1: return 16;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  // Footprint into fpb; returns 1 when it cannot fit in the table
  function automatic bit build_fp(int cls, int v, int lat);
    int p1 = second_mask(cls, v);
    bit mem = (cls >= 2);
    fpb[0] = first_mask(cls, v);
    for (int k = 1; k < DEPTH; k++)
      fpb[k] = mem ? ((k <= 1 + lat) ? p1 : 0) : ((k == 1) ? p1 : 0);
    return mem && (lat + 2 > DEPTH);
  endfunction

  task automatic step(bit v, int cls, int lat, string tag);
    bit rdy = 0; bit ovf = 0; int var_e = 0;
    @(negedge clk);
    in_valid = v; in_class = cls[1:0]; in_cache_lat = lat[3:0];
    #1;
    for (int c = 0; c < ncand(cls) && !rdy; c++) begin
      bit clash = 0;
      ovf = build_fp(cls, c, lat);
      for (int k = 0; k < DEPTH; k++) if ((fpb[k] & m_occ[k]) != 0) clash = 1;
      if (!ovf && !clash) begin rdy = 1; var_e = c; end
    end
    chk(tag, in_ready, rdy);
    chk("R11", issue_o, v && rdy);
    if (v && rdy && issue_o) chk(tag, issue_variant, var_e);
    chk("R8", cycle_count, m_cyc);
    chk("R6", issued_count, m_iss);
    if (v) begin
      if (rdy) begin
        void'(build_fp(cls, var_e, lat));
        for (int k = 0; k < DEPTH; k++) m_occ[k] |= fpb[k];
        m_iss++;
      end else if (!ovf) begin
        for (int k = 0; k < DEPTH - 1; k++) m_occ[k] = m_occ[k+1];
        m_occ[DEPTH-1] = 0;
        m_cyc++;
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < DEPTH; k++) m_occ[k] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", cycle_count, 0);
    chk("R1", issued_count, 0);
    chk("R1", in_ready, 1);
    chk("R1", issue_variant, 0);
    step(0, 0, 0, "R10");
    // ALU variants taken in order, fifth stalls then reuses a slot
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R2");
    step(1, 0, 0, "R5");
    step(0, 1, 0, "R10");
    // FPU back to back: waits for both cycles to drain
    for (int i = 0; i < 5; i++) step(1, 1, 0, "R3");
    // loads and stores with latency stretch
    step(1, 2, 3, "R4");
    step(1, 3, 0, "R4");
    for (int i = 0; i < 8; i++) step(1, 2, 0, "R7");
    // impossible latency held, no advance
    for (int i = 0; i < 3; i++) step(1, 3, 15, "R9");
    step(1, 2, 14, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R10");
    for (int i = 0; i < 20; i++) step(1, 3, 2, "R7");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(15);
      int lat = (r == 0) ? 15 : $urandom_range(4);
      step($urandom_range(3) != 0, $urandom_range(3), lat, "R5");
    end
    finish_run();
  end
endmodule